// File: doc/BRIEF.md
# Multi-Block Hash Compression Sequencer

This block drives a 1024-bit chaining state through one compression per 512-bit message block. For the first block of a message it builds the starting state from a small per-variant constant, mixes the message into the upper half of the state and hands the state to an external round engine for 42 rounds. It reports the round number on every cycle and takes the engine's result back the same cycle. After the last round it mixes the same block into the lower half of the state. It then either starts the next block of the same message at once, or presents a digest truncated to the width of the selected variant.

The round engine is combinational and sits outside the block. Each engine cycle receives `rnd_state_o` and `rnd_idx_o` and must return the updated state on `rnd_state_i` in the same cycle. Message padding, round logic and round-constant generation live elsewhere. A block costs 42 engine cycles plus one cycle for output. The first round shares its cycle with the opening mix, and the last round shares its cycle with the closing mix.

Top module: `hash_block_sequencer`

## Requirements
- R1: A synchronous reset, or the state in which reset leaves the block, gives `digest_vld_o`=0, `rnd_idx_o`=0 and `digest_o`=0. The sequencer idles and waits for `start`.
- R2: For the first block of a message, the starting state is the variant's digest width in bits, zero-extended to 1024 bits and placed at bits [15:0]. The variant codes are `ver_sel` 0 for 224, 1 for 256, 2 for 384 and 3 for 512. The variant is latched in the cycle that opens the first block and holds for the whole message.
- R3: In the opening cycle of a block, the engine receives the base state XORed with `{blk_in, 512'b0}`, so the block lands on bits [1023:512]. `blk_in` is sampled in that cycle.
- R4: `rnd_idx_o` runs 0, 1, …, 41, one step per enabled cycle, starting in the opening cycle. It is 0 outside a block.
- R5: In the cycle of round 41, the engine result is XORed with `{512'b0, block}` to form the new state. Here block is the copy registered in the opening cycle, so later changes on `blk_in` have no effect.
- R6: Let E be the clock edge that accepts `start`. Without chaining, `digest_vld_o` is high for exactly one cycle, after the 42nd edge that follows E. The block is idle again on the next edge.
- R7: `digest_o` carries bits [W-1:0] of the final state, with bits [511:W] zero, where W is the width of the latched variant.
- R8: If `more_blk` is 1 during the round-41 cycle, the next block opens on the following edge. That block uses the current state as its base instead of the starting constant, and `digest_vld_o` stays low in between.
- R9: While `en`=0, all state holds. The round index, the digest and the ready flag do not change, and completion is delayed by the number of frozen cycles.
- R10: `start` is ignored while a block is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; 0 freezes all state |
| start | input | 1 | Begin a message (sampled when idle) |
| blk_in | input | 512 | Message block |
| ver_sel | input | 2 | Digest variant select |
| more_blk | input | 1 | Another block of this message follows |
| rnd_state_o | output | 1024 | State handed to the round engine |
| rnd_state_i | input | 1024 | Round engine result |
| rnd_idx_o | output | 6 | Current round number |
| digest_o | output | 512 | Truncated digest, zero above the variant width |
| digest_vld_o | output | 1 | Digest valid, one cycle |

## Verification
A controller that slips by one count surfaces within one block. The ready pulse moves off its 42-cycle position and the round index skips or repeats, so every step of the index is compared against the expected count. A wrong mixing half, a stale message copy or a wrong variant latch cannot be seen until the digest appears 43 cycles later. At that point it changes the whole digest against an independent model that uses the same stand-in round. Chained messages and a variant switch in mid-message expose feedback errors one block later than single-block runs would.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_INIT, S_COMP, S_FIN, S_OUT} seq_st_e;

  function automatic logic [9:0] hseq_width(input logic [1:0] v);
    case (v)
      2'd0:    return 10'd224;
      2'd1:    return 10'd256;
      2'd2:    return 10'd384;
      default: return 10'd512;
    endcase
  endfunction
endpackage

// File: rtl/hseq_iv.sv
module hseq_iv
  import hseq_pkg::*;
#(
  parameter int STATE_W = 1024,
  parameter int IV_W    = 16
) (
  input  logic [1:0]         sel,
  output logic [STATE_W-1:0] iv_o
);
  localparam int PAD_W = STATE_W - IV_W;
  logic [IV_W-1:0] code;
  assign code = IV_W'(hseq_width(sel));
  assign iv_o = {{PAD_W{1'b0}}, code};
endmodule

// File: rtl/hseq_ctrl.sv
module hseq_ctrl
  import hseq_pkg::*;
#(
  parameter int ROUNDS = 42,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             more,
  output seq_st_e          fsm_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             rdy_q,
  output logic             chain_q
);
  localparam logic [IDX_W-1:0] LAST_COMP = IDX_W'(ROUNDS - 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q   <= S_IDLE;
      idx_q   <= '0;
      rdy_q   <= 1'b0;
      chain_q <= 1'b0;
    end else if (en) begin
      case (fsm_q)
        S_IDLE: begin
          idx_q <= '0;
          if (start) fsm_q <= S_INIT;
        end
        S_INIT: begin
          idx_q   <= idx_q + 1'b1;
          chain_q <= 1'b0;
          fsm_q   <= S_COMP;
        end
        S_COMP: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_COMP) fsm_q <= S_FIN;
        end
        S_FIN: begin
          idx_q <= '0;
          if (more) begin
            fsm_q   <= S_INIT;
            chain_q <= 1'b1;
          end else begin
            fsm_q <= S_OUT;
            rdy_q <= 1'b1;
          end
        end
        S_OUT: begin
          rdy_q <= 1'b0;
          fsm_q <= S_IDLE;
        end
        default: fsm_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hseq_datapath.sv
module hseq_datapath
  import hseq_pkg::*;
#(
  parameter int STATE_W = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  seq_st_e            fsm,
  input  logic               chain,
  input  logic               more,
  input  logic [1:0]         ver_sel,
  input  logic [STATE_W-1:0] iv,
  input  logic [STATE_W/2-1:0] blk_in,
  output logic [STATE_W-1:0] eng_o,
  input  logic [STATE_W-1:0] eng_i,
  output logic [STATE_W/2-1:0] dig_o
);
  localparam int HALF = STATE_W / 2;

  logic [STATE_W-1:0] st_q;
  logic [HALF-1:0]    msg_q;
  logic [HALF-1:0]    dig_q;
  logic [1:0]         ver_q;
  logic [STATE_W-1:0] base;
  logic [STATE_W-1:0] opened;
  logic [STATE_W-1:0] closed;
  logic [HALF-1:0]    keep;
  logic [9:0]         keep_bits;

  assign base   = chain ? st_q : iv;
  assign opened = base ^ {blk_in, {HALF{1'b0}}};
  assign closed = eng_i ^ {{HALF{1'b0}}, msg_q};
  assign eng_o  = (fsm == S_INIT) ? opened : st_q;
  assign keep_bits = hseq_width(ver_q);

  for (genvar g = 0; g < HALF; g++) begin : g_keep
    assign keep[g] = (g < int'(keep_bits));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      msg_q <= '0;
      dig_q <= '0;
      ver_q <= '0;
    end else if (en) begin
      case (fsm)
        S_INIT: begin
          st_q  <= eng_i;
          msg_q <= blk_in;
          if (!chain) ver_q <= ver_sel;
        end
        S_COMP: st_q <= eng_i;
        S_FIN: begin
          st_q <= closed;
          if (!more) dig_q <= closed[HALF-1:0] & keep;
        end
        default: ;
      endcase
    end
  end

  assign dig_o = dig_q;
endmodule

// File: rtl/hash_block_sequencer.sv
module hash_block_sequencer
  import hseq_pkg::*;
#(
  parameter int STATE_W = 1024,
  parameter int ROUNDS  = 42,
  parameter int IV_W    = 16,
  parameter int IDX_W   = $clog2(ROUNDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  input  logic [STATE_W/2-1:0] blk_in,
  input  logic [1:0]           ver_sel,
  input  logic                 more_blk,
  output logic [STATE_W-1:0]   rnd_state_o,
  input  logic [STATE_W-1:0]   rnd_state_i,
  output logic [IDX_W-1:0]     rnd_idx_o,
  output logic [STATE_W/2-1:0] digest_o,
  output logic                 digest_vld_o
);
  seq_st_e            fsm;
  logic               chain;
  logic [STATE_W-1:0] iv;

  hseq_ctrl #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .start(start), .more(more_blk),
    .fsm_q(fsm), .idx_q(rnd_idx_o), .rdy_q(digest_vld_o), .chain_q(chain)
  );

  hseq_iv #(.STATE_W(STATE_W), .IV_W(IV_W)) u_iv (
    .sel(ver_sel), .iv_o(iv)
  );

  hseq_datapath #(.STATE_W(STATE_W)) u_dp (
    .clk(clk), .rst(rst), .en(en), .fsm(fsm), .chain(chain),
    .more(more_blk), .ver_sel(ver_sel), .iv(iv), .blk_in(blk_in),
    .eng_o(rnd_state_o), .eng_i(rnd_state_i), .dig_o(digest_o)
  );
endmodule

// File: rtl/hseq_chk.sv
module hseq_chk
  import hseq_pkg::*;
#(
  parameter int ROUNDS = 42,
  parameter int IDX_W  = 6,
  parameter int DIG_W  = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             start,
  input logic             more_blk,
  input seq_st_e          fsm,
  input logic [IDX_W-1:0] rnd_idx_o,
  input logic [DIG_W-1:0] digest_o,
  input logic             digest_vld_o
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!digest_vld_o && rnd_idx_o == '0 && fsm == S_IDLE));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
    (en && (fsm == S_INIT || fsm == S_COMP)) |=> rnd_idx_o == IDX_W'($past(rnd_idx_o) + 1'b1));

  a_r4_idx_bound: assert property (@(posedge clk) disable iff (rst)
    rnd_idx_o < IDX_W'(ROUNDS));

  a_r6_fin_to_ready: assert property (@(posedge clk) disable iff (rst)
    (en && fsm == S_FIN && !more_blk) |=> digest_vld_o);

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    (en && digest_vld_o) |=> !digest_vld_o);

  a_r8_chain_reopens: assert property (@(posedge clk) disable iff (rst)
    (en && fsm == S_FIN && more_blk) |=> (fsm == S_INIT && !digest_vld_o));

  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    (armed && !en) |=> ($stable(rnd_idx_o) && $stable(digest_vld_o) && $stable(digest_o)));

  a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (en && fsm == S_COMP && start) |=> fsm != S_INIT);
endmodule

bind hash_block_sequencer hseq_chk #(
  .ROUNDS(ROUNDS), .IDX_W(IDX_W), .DIG_W(STATE_W/2)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .start(start), .more_blk(more_blk),
  .fsm(fsm), .rnd_idx_o(rnd_idx_o), .digest_o(digest_o), .digest_vld_o(digest_vld_o)
);

// File: tb/sim_hash_block_sequencer.sv
module sim_hash_block_sequencer;
  localparam int SW = 1024;
  localparam int BW = 512;
  localparam int NR = 42;
  localparam int IW = 6;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          start = 1'b0;
  logic [BW-1:0] blk_in = '0;
  logic [1:0]    ver_sel = '0;
  logic          more_blk = 1'b0;
  logic [SW-1:0] rnd_state_o, rnd_state_i;
  logic [IW-1:0] rnd_idx_o;
  logic [BW-1:0] digest_o;
  logic          digest_vld_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [SW-1:0] stub_rnd(input logic [SW-1:0] s, input logic [IW-1:0] r);
    return {s[SW-2:0], s[SW-1]} ^ SW'(r) ^ (SW'(r) << 600);
  endfunction

  assign rnd_state_i = stub_rnd(rnd_state_o, rnd_idx_o);

  hash_block_sequencer u0 (
    .clk(clk), .rst(rst), .en(en), .start(start), .blk_in(blk_in),
    .ver_sel(ver_sel), .more_blk(more_blk), .rnd_state_o(rnd_state_o),
    .rnd_state_i(rnd_state_i), .rnd_idx_o(rnd_idx_o), .digest_o(digest_o),
    .digest_vld_o(digest_vld_o)
  );

  function automatic int var_bits(input logic [1:0] v);
    case (v)
      2'd0: return 224;
      2'd1: return 256;
      2'd2: return 384;
      default: return 512;
    endcase
  endfunction

  function automatic logic [BW-1:0] mk_blk(input logic [31:0] seed);
    logic [BW-1:0] b;
    for (int w = 0; w < BW / 32; w++) b[w*32 +: 32] = seed * (w + 3) ^ (32'h9e3779b9 + w);
    return b;
  endfunction

  function automatic logic [BW-1:0] model(input logic [1:0] v, input logic [BW-1:0] b0,
                                          input logic [BW-1:0] b1, input int n);
    logic [SW-1:0] h, s;
    logic [BW-1:0] b, o;
    h = SW'(var_bits(v));
    for (int j = 0; j < n; j++) begin
      b = (j == 0) ? b0 : b1;
      s = h ^ {b, {BW{1'b0}}};
      for (int r = 0; r < NR; r++) s = stub_rnd(s, IW'(r));
      h = s ^ {{BW{1'b0}}, b};
    end
    for (int i = 0; i < BW; i++) o[i] = (i < var_bits(v)) ? h[i] : 1'b0;
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_msg(input logic [1:0] v, input logic [BW-1:0] b0, input logic [BW-1:0] b1,
                         input int n, input bit poke);
    int idx_err = 0;
    int rdy_err = 0;
    logic [BW-1:0] exp;
    exp = model(v, b0, b1, n);
    @(negedge clk);
    start = 1'b1; ver_sel = v; blk_in = b0; more_blk = (n > 1);
    for (int k = 1; k <= NR * n + 2; k++) begin
      @(negedge clk);
      if (rnd_idx_o != IW'((k <= NR * n) ? (k - 1) % NR : 0)) idx_err++;
      if (digest_vld_o != (k == NR * n + 1)) rdy_err++;
      if (k == NR * n + 1)
        chk(digest_o == exp, "R2 R3 R5 R7 R8 digest", digest_o, exp);
      if (k == 1) start = 1'b0;
      if (k == 2) begin blk_in = b1; ver_sel = ~v; end
      if (k == NR + 1) more_blk = 1'b0;
      if (k == NR + 2) blk_in = ~b0;
      if (poke && k == 20) start = 1'b1;
      if (poke && k == 21) start = 1'b0;
    end
    chk(idx_err == 0, "R4 round index sequence", BW'(idx_err), '0);
    chk(rdy_err == 0, "R6 R8 R10 ready timing", BW'(rdy_err), '0);
  endtask

  localparam logic [1:0]  TV_VER [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};
  localparam logic [31:0] TV_SEED[NV] = '{32'h1234_5678, 32'hcafe_0001, 32'h0bad_f00d,
                                          32'h7777_3333, 32'h5a5a_a5a5, 32'h0000_0001};
  localparam int          TV_N   [NV] = '{1, 1, 1, 1, 2, 2};
  localparam bit          TV_POKE[NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(digest_vld_o == 1'b0 && rnd_idx_o == '0 && digest_o == '0, "R1 reset state",
        {digest_vld_o, BW'(rnd_idx_o)}, '0);

    for (int i = 0; i < NV; i++)
      run_msg(TV_VER[i], mk_blk(TV_SEED[i]), mk_blk(~TV_SEED[i] + 32'(i)), TV_N[i], TV_POKE[i]);

    begin : freeze_test
      logic [BW-1:0] b, exp;
      int hold_err = 0;
      b = mk_blk(32'hfeed_beef);
      exp = model(2'd3, b, b, 1);
      @(negedge clk);
      start = 1'b1; ver_sel = 2'd3; blk_in = b; more_blk = 1'b0;
      @(negedge clk); start = 1'b0;
      repeat (9) @(negedge clk);
      chk(rnd_idx_o == IW'(9), "R4 index before freeze", BW'(rnd_idx_o), BW'(9));
      en = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (rnd_idx_o != IW'(9) || digest_vld_o) hold_err++;
      end
      chk(hold_err == 0, "R9 frozen index and ready", BW'(hold_err), '0);
      en = 1'b1;
      repeat (32) @(negedge clk);
      chk(digest_vld_o == 1'b0, "R9 ready delayed by freeze", BW'(digest_vld_o), '0);
      @(negedge clk);
      chk(digest_vld_o == 1'b1 && digest_o == exp, "R9 R7 digest after freeze", digest_o, exp);
    end

    begin : reset_test
      @(negedge clk);
      start = 1'b1; ver_sel = 2'd0; blk_in = mk_blk(32'h42);
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(digest_vld_o == 1'b0 && rnd_idx_o == '0 && digest_o == '0, "R1 mid-block reset",
          {digest_vld_o, BW'(rnd_idx_o)}, '0);
      repeat (3) @(negedge clk);
      chk(rnd_idx_o == '0 && digest_vld_o == 1'b0, "R1 idle after reset", BW'(rnd_idx_o), '0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule